// File: doc/BRIEF.md
# Depth Tile Delta Run-Length Codec

This block shrinks one rectangular tile of depth samples before it goes to external memory, and expands it again when it comes back. Pixels of a single planar triangle change depth by the same amount from one pixel to the next. The encoder therefore takes the difference between each pixel and the pixel before it in raster order. It stores each run of equal differences only once, as a token that holds the difference and a repeat count. The tile starts with an anchor word that holds the first pixel unchanged. If the tokens would take more bits than the plain tile, the encoder sends the tile raw and raises a mode flag with every word. The memory side stores that flag next to the tile.

The encoder and the decoder are independent paths in one module. The encoder takes pixels on a valid/ready stream. It buffers the whole tile, because the mode must be known before the first word leaves. It then drains packed words on a second valid/ready stream. The decoder takes those words, together with the stored mode flag, and produces one depth value per accepted output beat. On every stream a beat transfers only on a clock edge where valid and ready are both high. A source holds valid, data and flags steady until the beat transfers. The encoder lowers its input ready from the last pixel of a tile until the tile's final word has transferred. The decoder raises its input ready only on the output beat that finishes the current word. Back-pressure on the decoder output therefore stalls its input directly.

Top module: `depth_tile_codec`

## Requirements
- R1: While reset is held, the encoder offers input ready, and it has no output word valid.
- R2: The encoder accepts exactly TILE_W*TILE_H pixels for a tile. Its input ready then stays low until the tile's last word has transferred, and the input ready and the output valid are never high together.
- R3: A compressed tile is sent as an anchor word first, then its tokens. The anchor holds the first pixel in bits [DEPTH_W-1:0], with zeros above. A token holds the signed difference (current pixel minus previous pixel, DEPTH_W+1 bits) in bits [DEPTH_W+RUN_W:RUN_W], and the repeat count minus one in bits [RUN_W-1:0].
- R4: A token closes when the next difference is not equal to it, or when it already covers 2**RUN_W repeats. A tile of all-equal differences therefore splits into several tokens, every one full except the last.
- R5: With T tokens, a tile is sent raw when DEPTH_W + T*(DEPTH_W+1+RUN_W) > TILE_W*TILE_H*DEPTH_W. A raw tile is one word for each pixel, in raster order, zero-extended. The mode flag is 1 for raw and 0 for compressed, and it keeps the same value on every word of the tile.
- R6: The encoder's last flag is high only on the final word of a tile, and the encoder accepts input again on the cycle after that word transfers.
- R7: While an encoder output word is valid and not accepted, the word, its mode flag and its last flag do not change.
- R8: The decoder emits one pixel on every cycle in which its input is valid and its output is ready. In compressed mode it adds the token's difference, modulo 2**DEPTH_W, to the previous pixel. It consumes a token only on the output beat that completes the token's last repeat, and it never consumes a word without emitting a pixel.
- R9: The decoder raises its last flag on the tile's final pixel. The word that follows that pixel is taken as the next tile's anchor, or as a raw pixel.
- R10: Decoding the words that the encoder produced, with their mode flag, gives back the original tile. This holds for planar, constant, ramp and random tiles, and for tiles with differences at both extremes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_in_valid | input | 1 | Pixel offered to the encoder |
| enc_in_ready | output | 1 | Encoder can take a pixel |
| enc_in_depth | input | DEPTH_W | Depth pixel, raster order |
| enc_out_valid | output | 1 | Packed word available |
| enc_out_ready | input | 1 | Sink takes the packed word |
| enc_out_word | output | DEPTH_W+1+RUN_W | Anchor, token or raw pixel |
| enc_out_raw | output | 1 | Mode flag of the tile (1 = raw) |
| enc_out_last | output | 1 | Final word of the tile |
| dec_in_valid | input | 1 | Packed word offered to the decoder |
| dec_in_ready | output | 1 | Decoder has finished with the word |
| dec_in_word | input | DEPTH_W+1+RUN_W | Packed word |
| dec_in_raw | input | 1 | Stored mode flag of the tile |
| dec_out_valid | output | 1 | Rebuilt pixel available |
| dec_out_ready | input | 1 | Sink takes the pixel |
| dec_out_depth | output | DEPTH_W | Rebuilt depth pixel |
| dec_out_last | output | 1 | Final pixel of the tile |

## Verification
The bench uses a 128-pixel tile so that runs can reach the repeat cap. A constant tile and a constant ramp must split into a full 64-repeat token and a 63-repeat token. A design that never capped the count would wrap the count field, and the tile would decode to the wrong length. Two tiles are built with exactly 98 and 99 tokens, which sit on either side of the raw threshold. An off-by-one in the size comparison flips the mode on one of them. Tiles that jump between zero and full scale check the sign extension of the difference, and a falling ramp checks negative differences. The readiness signals on both streams are toggled at random. A decoder that consumed a token early, or dropped a pixel under stall, would shift every later pixel. A planar tile with no back-pressure must decode in exactly one cycle per pixel.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  // Encoder phases: gather the tile, close the open token and pick the mode, drain words.
  typedef enum logic [1:0] {
    ENC_FILL = 2'd0,
    ENC_SEAL = 2'd1,
    ENC_SEND = 2'd2
  } enc_state_e;

endpackage

// File: rtl/dtc_mode_judge.sv
module dtc_mode_judge #(
  parameter int DEPTH_W = 24,
  parameter int TOK_W   = 31,
  parameter int NPIX    = 16,
  parameter int CNT_W   = 4
) (
  input  logic [CNT_W-1:0] tok_count,
  output logic             use_raw
);

  localparam int unsigned RAW_BITS = NPIX * DEPTH_W;

  logic [31:0] packed_bits;

  // Anchor plus all tokens, in bits.
  assign packed_bits = 32'(DEPTH_W) + 32'(tok_count) * 32'(TOK_W);
  assign use_raw     = packed_bits > RAW_BITS;

endmodule

// File: rtl/dtc_encoder.sv
module dtc_encoder
  import dtc_pkg::*;
#(
  parameter int DEPTH_W = 24,
  parameter int RUN_W   = 6,
  parameter int NPIX    = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic [DEPTH_W-1:0]               in_depth,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic [DEPTH_W+RUN_W:0]           out_word,
  output logic                             out_raw,
  output logic                             out_last
);

  localparam int DELTA_W = DEPTH_W + 1;
  localparam int TOK_W   = DELTA_W + RUN_W;
  localparam int IDX_W   = (NPIX > 2) ? $clog2(NPIX) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPIX - 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = '1;

  enc_state_e                 state;
  logic [DEPTH_W-1:0]         pix_mem [NPIX];
  logic [TOK_W-1:0]           tok_mem [NPIX];
  logic [IDX_W-1:0]           idx, tcnt, oidx, seal_cnt, tok_ridx;
  logic signed [DELTA_W-1:0]  cur_delta, delta_in;
  logic [RUN_W-1:0]           cur_run;
  logic [DEPTH_W-1:0]         prev;
  logic                       have_tok, raw_q, use_raw;
  logic                       accept, extend, tok_we;

  assign in_ready = (state == ENC_FILL);
  assign accept   = in_valid && in_ready;
  assign delta_in = $signed({1'b0, in_depth}) - $signed({1'b0, prev});
  assign extend   = have_tok && (delta_in == cur_delta) && (cur_run != RUN_MAX);
  // A token is written when a new difference replaces an open one, or when the tile is sealed.
  assign tok_we   = (accept && (idx != '0) && have_tok && !extend) ||
                    ((state == ENC_SEAL) && have_tok);
  assign seal_cnt = tcnt + IDX_W'(have_tok);

  dtc_mode_judge #(
    .DEPTH_W (DEPTH_W),
    .TOK_W   (TOK_W),
    .NPIX    (NPIX),
    .CNT_W   (IDX_W)
  ) u_judge (
    .tok_count (seal_cnt),
    .use_raw   (use_raw)
  );

  // Tile and token storage, no reset needed.
  always_ff @(posedge clk) begin
    if (accept) pix_mem[idx] <= in_depth;
    if (tok_we) tok_mem[tcnt] <= {cur_delta, cur_run};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ENC_FILL;
      idx       <= '0;
      tcnt      <= '0;
      oidx      <= '0;
      cur_delta <= '0;
      cur_run   <= '0;
      have_tok  <= 1'b0;
      raw_q     <= 1'b0;
      prev      <= '0;
    end else begin
      case (state)
        ENC_FILL: begin
          if (accept) begin
            prev <= in_depth;
            if (idx != '0) begin
              if (extend) begin
                cur_run <= cur_run + 1'b1;
              end else begin
                cur_delta <= delta_in;
                cur_run   <= '0;
                have_tok  <= 1'b1;
                if (have_tok) tcnt <= tcnt + 1'b1;
              end
            end
            if (idx == LAST_IDX) begin
              idx   <= '0;
              state <= ENC_SEAL;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ENC_SEAL: begin
          tcnt     <= seal_cnt;
          raw_q    <= use_raw;
          have_tok <= 1'b0;
          oidx     <= '0;
          state    <= ENC_SEND;
        end
        ENC_SEND: begin
          if (out_ready) begin
            if (out_last) begin
              oidx  <= '0;
              tcnt  <= '0;
              state <= ENC_FILL;
            end else begin
              oidx <= oidx + 1'b1;
            end
          end
        end
        default: state <= ENC_FILL;
      endcase
    end
  end

  assign out_valid = (state == ENC_SEND);
  assign out_raw   = raw_q;
  assign tok_ridx  = oidx - 1'b1;

  always_comb begin
    if (raw_q || (oidx == '0)) out_word = TOK_W'(pix_mem[oidx]);
    else                       out_word = tok_mem[tok_ridx];
    out_last = raw_q ? (oidx == LAST_IDX) : (oidx == tcnt);
  end

endmodule

// File: rtl/dtc_decoder.sv
module dtc_decoder #(
  parameter int DEPTH_W = 24,
  parameter int RUN_W   = 6,
  parameter int NPIX    = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [DEPTH_W+RUN_W:0] in_word,
  input  logic                   in_raw,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [DEPTH_W-1:0]     out_depth,
  output logic                   out_last
);

  localparam int DELTA_W = DEPTH_W + 1;
  localparam int TOK_W   = DELTA_W + RUN_W;
  localparam int IDX_W   = (NPIX > 2) ? $clog2(NPIX) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPIX - 1);

  logic [IDX_W-1:0]   pcnt;
  logic [RUN_W-1:0]   rep, tok_run;
  logic [DELTA_W-1:0] tok_delta;
  logic [DEPTH_W-1:0] prev;
  logic               literal, tok_done, step;

  assign tok_run   = in_word[RUN_W-1:0];
  assign tok_delta = in_word[TOK_W-1:RUN_W];
  // Raw words and the first word of a compressed tile carry the pixel itself.
  assign literal   = in_raw || (pcnt == '0);
  assign tok_done  = literal || (rep == tok_run);
  assign step      = in_valid && out_ready;

  assign out_valid = in_valid;
  assign in_ready  = out_ready && tok_done;
  assign out_last  = (pcnt == LAST_IDX);
  assign out_depth = literal ? in_word[DEPTH_W-1:0]
                             : DEPTH_W'({1'b0, prev} + tok_delta);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      rep  <= '0;
      prev <= '0;
    end else if (step) begin
      prev <= out_depth;
      pcnt <= out_last ? '0 : pcnt + 1'b1;
      rep  <= tok_done ? '0 : rep + 1'b1;
    end
  end

endmodule

// File: rtl/depth_tile_codec.sv
module depth_tile_codec #(
  parameter int TILE_W  = 4,
  parameter int TILE_H  = 4,
  parameter int DEPTH_W = 24,
  parameter int RUN_W   = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enc_in_valid,
  output logic                   enc_in_ready,
  input  logic [DEPTH_W-1:0]     enc_in_depth,
  output logic                   enc_out_valid,
  input  logic                   enc_out_ready,
  output logic [DEPTH_W+RUN_W:0] enc_out_word,
  output logic                   enc_out_raw,
  output logic                   enc_out_last,
  input  logic                   dec_in_valid,
  output logic                   dec_in_ready,
  input  logic [DEPTH_W+RUN_W:0] dec_in_word,
  input  logic                   dec_in_raw,
  output logic                   dec_out_valid,
  input  logic                   dec_out_ready,
  output logic [DEPTH_W-1:0]     dec_out_depth,
  output logic                   dec_out_last
);

  localparam int NPIX = TILE_W * TILE_H;

  dtc_encoder #(
    .DEPTH_W (DEPTH_W),
    .RUN_W   (RUN_W),
    .NPIX    (NPIX)
  ) u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (enc_in_valid),
    .in_ready  (enc_in_ready),
    .in_depth  (enc_in_depth),
    .out_valid (enc_out_valid),
    .out_ready (enc_out_ready),
    .out_word  (enc_out_word),
    .out_raw   (enc_out_raw),
    .out_last  (enc_out_last)
  );

  dtc_decoder #(
    .DEPTH_W (DEPTH_W),
    .RUN_W   (RUN_W),
    .NPIX    (NPIX)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (dec_in_valid),
    .in_ready  (dec_in_ready),
    .in_word   (dec_in_word),
    .in_raw    (dec_in_raw),
    .out_valid (dec_out_valid),
    .out_ready (dec_out_ready),
    .out_depth (dec_out_depth),
    .out_last  (dec_out_last)
  );

endmodule

// File: rtl/dtc_checker.sv
module dtc_checker #(
  parameter int TOK_W = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enc_in_ready,
  input logic             enc_out_valid,
  input logic             enc_out_ready,
  input logic [TOK_W-1:0] enc_out_word,
  input logic             enc_out_raw,
  input logic             enc_out_last,
  input logic             dec_in_valid,
  input logic             dec_in_ready,
  input logic             dec_out_valid,
  input logic             dec_out_ready,
  input logic             dec_out_last
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (enc_in_ready && !enc_out_valid);
    end
  end

  // R2
  fill_send_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(enc_in_ready && enc_out_valid));

  // R7
  enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_out_valid && !enc_out_ready) |=>
      (enc_out_valid && $stable(enc_out_word) && $stable(enc_out_raw) && $stable(enc_out_last)));

  // R5
  raw_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_out_valid && enc_out_ready && !enc_out_last) |=>
      (enc_out_valid && (enc_out_raw == $past(enc_out_raw))));

  // R6
  last_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_out_valid && enc_out_ready && enc_out_last) |=> (enc_in_ready && !enc_out_valid));

  // R8
  dec_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_in_valid && dec_in_ready) |-> (dec_out_valid && dec_out_ready));

  // R9
  dec_last_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && dec_out_ready && dec_out_last) |=> !dec_out_last);

endmodule

bind depth_tile_codec dtc_checker #(
  .TOK_W (DEPTH_W + 1 + RUN_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .enc_in_ready  (enc_in_ready),
  .enc_out_valid (enc_out_valid),
  .enc_out_ready (enc_out_ready),
  .enc_out_word  (enc_out_word),
  .enc_out_raw   (enc_out_raw),
  .enc_out_last  (enc_out_last),
  .dec_in_valid  (dec_in_valid),
  .dec_in_ready  (dec_in_ready),
  .dec_out_valid (dec_out_valid),
  .dec_out_ready (dec_out_ready),
  .dec_out_last  (dec_out_last)
);

// File: tb/tb_depth_tile_codec.sv
`timescale 1ns/1ps
module tb_depth_tile_codec;

  localparam int TW = 16;
  localparam int TH = 8;
  localparam int N  = TW * TH;
  localparam int DW = 24;
  localparam int RW = 6;
  localparam int WW = DW + 1 + RW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enc_in_valid = 1'b0, enc_out_ready = 1'b0;
  logic [DW-1:0] enc_in_depth = '0;
  logic          enc_in_ready, enc_out_valid, enc_out_raw, enc_out_last;
  logic [WW-1:0] enc_out_word;
  logic          dec_in_valid = 1'b0, dec_in_raw = 1'b0, dec_out_ready = 1'b0;
  logic [WW-1:0] dec_in_word = '0;
  logic          dec_in_ready, dec_out_valid, dec_out_last;
  logic [DW-1:0] dec_out_depth;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [DW-1:0] tile [N];
  logic [WW-1:0] expw [N+1];
  logic [WW-1:0] got  [N+1];
  int            exp_n;
  bit            exp_raw;

  always #2.5 clk = ~clk;

  depth_tile_codec #(.TILE_W(TW), .TILE_H(TH), .DEPTH_W(DW), .RUN_W(RW)) dut (
    .clk(clk), .rst_n(rst_n),
    .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready), .enc_in_depth(enc_in_depth),
    .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready), .enc_out_word(enc_out_word),
    .enc_out_raw(enc_out_raw), .enc_out_last(enc_out_last),
    .dec_in_valid(dec_in_valid), .dec_in_ready(dec_in_ready), .dec_in_word(dec_in_word),
    .dec_in_raw(dec_in_raw), .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready),
    .dec_out_depth(dec_out_depth), .dec_out_last(dec_out_last)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Watchdog: a hung run counts as a failure.
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      finish_run();
    end
  end

  // Expected stream from the requirements: R3 layout, R4 run cap, R5 size rule.
  task automatic model_encode();
    int t = 0;
    logic signed [DW:0] cd = '0;
    int cr = 0;
    for (int i = 1; i < N; i++) begin
      logic signed [DW:0] d;
      d = $signed({1'b0, tile[i]}) - $signed({1'b0, tile[i-1]});
      if (i > 1 && d == cd && cr < (1 << RW) - 1) cr++;
      else begin
        if (i > 1) begin expw[t+1] = {cd, RW'(cr)}; t++; end
        cd = d;
        cr = 0;
      end
    end
    expw[t+1] = {cd, RW'(cr)};
    t++;
    exp_raw = (DW + t * WW) > (N * DW);
    if (exp_raw) begin
      for (int i = 0; i < N; i++) expw[i] = WW'(tile[i]);
      exp_n = N;
    end else begin
      expw[0] = WW'(tile[0]);
      exp_n = t + 1;
    end
  endtask

  task automatic run_tile(input string name, input bit full_rate, input int exp_tokens);
    int  sent = 0, nrx = 0, fed = 0, np = 0, guard = 0, dcyc = 0;
    bit  done = 0, early = 0;
    model_encode();
    if (exp_tokens >= 0)
      check(exp_n == exp_tokens + 1 || exp_raw, "R5", {name, " bench token count"},
            exp_n - 1, exp_tokens);
    // Encode
    while (!done && guard < 4000) begin
      @(negedge clk);
      guard++;
      enc_in_valid  = 1'b1;
      enc_in_depth  = (sent < N) ? tile[sent] : 24'hABCDEF;
      enc_out_ready = full_rate ? 1'b1 : (($urandom % 4) != 0);
      #1;
      if (sent == N && enc_in_ready) early = 1;
      if (enc_in_valid && enc_in_ready && sent < N) sent++;
      if (enc_out_valid && enc_out_ready) begin
        logic [WW-1:0] ew;
        bit el;
        ew = (nrx < exp_n) ? expw[nrx] : '0;
        el = (nrx == exp_n - 1);
        check(enc_out_word == ew, "R3/R5", {name, " word"}, enc_out_word, ew);
        check(enc_out_raw == exp_raw, "R5", {name, " mode flag"}, enc_out_raw, exp_raw);
        check(enc_out_last == el, "R6", {name, " last flag"}, enc_out_last, el);
        if (nrx <= N) got[nrx] = enc_out_word;
        nrx++;
        if (enc_out_last || nrx > N) done = 1;
      end
    end
    @(negedge clk);
    enc_in_valid  = 1'b0;
    enc_out_ready = 1'b0;
    check(nrx == exp_n, "R5/R6", {name, " word count"}, nrx, exp_n);
    check(!early, "R2", {name, " input ready during drain"}, early, 0);
    // Decode
    done = 0;
    guard = 0;
    while (!done && guard < 4000) begin
      @(negedge clk);
      guard++;
      dec_in_valid  = (fed < nrx) && (full_rate || (($urandom % 3) != 0));
      dec_in_word   = (fed < nrx && fed <= N) ? got[fed] : '0;
      dec_in_raw    = exp_raw;
      dec_out_ready = full_rate ? 1'b1 : (($urandom % 4) != 0);
      #1;
      dcyc++;
      if (dec_out_valid && dec_out_ready) begin
        bit el;
        el = (np == N - 1);
        check(dec_out_depth == tile[np], "R10/R8", {name, " pixel"}, dec_out_depth, tile[np]);
        check(dec_out_last == el, "R9", {name, " pixel last"}, dec_out_last, el);
        np++;
        if (np == N) done = 1;
      end
      if (dec_in_valid && dec_in_ready) fed++;
    end
    @(negedge clk);
    dec_in_valid  = 1'b0;
    dec_out_ready = 1'b0;
    check(np == N, "R10", {name, " pixel count"}, np, N);
    check(fed == nrx, "R8", {name, " words consumed"}, fed, nrx);
    if (full_rate)
      check(dcyc == N, "R8", {name, " cycles at full rate"}, dcyc, N);
  endtask

  initial begin
    // R1: reset state
    #1;
    check(enc_in_ready == 1'b1, "R1", "enc_in_ready in reset", enc_in_ready, 1);
    check(enc_out_valid == 1'b0, "R1", "enc_out_valid in reset", enc_out_valid, 0);
    check(dec_out_valid == 1'b0, "R1", "dec_out_valid in reset", dec_out_valid, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Planar tile: row steps differ from column steps (R3, R8 full rate)
    for (int y = 0; y < TH; y++)
      for (int x = 0; x < TW; x++) tile[y*TW + x] = DW'(5000 + 3*x + 40*y);
    run_tile("planar", 1'b1, 15);
    run_tile("planar_bp", 1'b0, 15);

    // Constant tile: 127 zero differences split at the run cap (R4)
    for (int i = 0; i < N; i++) tile[i] = 24'h123456;
    run_tile("constant", 1'b0, 2);

    // Rising ramp: one difference, split at the cap (R4)
    for (int i = 0; i < N; i++) tile[i] = DW'(100 + 7*i);
    run_tile("ramp", 1'b0, 2);

    // Falling ramp: negative difference (R3)
    for (int i = 0; i < N; i++) tile[i] = DW'(24'hFFFFF0 - 5*i);
    run_tile("fall", 1'b0, 2);

    // Extreme jumps: +max then zeros, and -max then zeros (R3, R10)
    tile[0] = '0;
    for (int i = 1; i < N; i++) tile[i] = 24'hFFFFFF;
    run_tile("jump_up", 1'b0, 3);
    tile[0] = 24'hFFFFFF;
    for (int i = 1; i < N; i++) tile[i] = '0;
    run_tile("jump_down", 1'b0, 3);

    // Threshold tiles: 98 tokens stay compressed, 99 tokens go raw (R5)
    for (int tk = 98; tk <= 99; tk++) begin
      tile[0] = 24'd1000;
      for (int i = 1; i < N; i++) begin
        int d;
        d = (i <= tk - 1) ? ((i % 2) ? 1 : 2) : 9;
        tile[i] = tile[i-1] + DW'(d);
      end
      run_tile(tk == 98 ? "edge98" : "edge99", 1'b0, tk);
    end

    // Random tiles: raw fallback (R5, R10)
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < N; i++) tile[i] = DW'($urandom);
      run_tile("random", 1'b0, -1);
    end

    // Alternating extremes: every difference differs, raw (R5)
    for (int i = 0; i < N; i++) tile[i] = (i % 2) ? 24'hFFFFFF : 24'h000000;
    run_tile("alternate", 1'b0, 127);

    finish_run();
  end

endmodule